// File: doc/BRIEF.md
# Gapped Receive System Clock Generator

This block produces a gapped bit clock for the system side of a framed 1.544 Mb/s receive path. A free-running bit-rate tick comes in. The block turns it into a clock-enable, `clk_en_o`, that fires once per line bit. That enable is withheld during bit positions the user chooses to blank. Downstream logic uses `clk_en_o` as the gapped system clock. It reads `dont_care_o` to know which bit slots carry meaningless data.

The block tracks its place in a 193-bit frame. Position 0 is the framing bit. Positions 1 to 192 hold 24 channels of 8 bits each, and bit 1 of each channel comes first. A frame-start pulse, taken together with a tick, puts the counter back at the framing bit. If no frame start arrives, the counter wraps by itself.

Three independent rules can blank a bit:
- The framing-bit rule blanks the framing bit.
- The channel rule blanks every bit of each channel selected in a 24-bit mask.
- The 56 kb/s rule blanks only bit 8 of every channel.

The three rules are combined by OR. The rule settings are latched at each frame start, so one frame always runs on one consistent set of settings.

Top module: `gapped_sysclk_gen`

## Requirements
- R1: After reset, `pos_o` is 192, and `clk_en_o` and `dont_care_o` are both 0.
- R2: Each cycle with `bit_tick` high produces exactly one cycle of `clk_en_o` on the next cycle, unless that bit is gapped. A cycle without `bit_tick` is followed by a cycle where `clk_en_o` and `dont_care_o` are both 0.
- R3: If `frame_start` and `bit_tick` are high together, `pos_o` is 0 on the next cycle. A `frame_start` pulse without `bit_tick` is ignored.
- R4: Each tick without frame start moves `pos_o` up by one, and 192 wraps to 0. Without a tick, `pos_o` holds its value.
- R5: At position 0, `chan_o` and `bit_o` are both 0. At position p from 1 to 192, `chan_o` = (p-1)/8+1 and `bit_o` = (p-1)%8+1.
- R6: With the latched framing-bit gap control at 1, the tick at position 0 gives no pulse.
- R7: With the latched channel gap control at 1, every bit of channel c gives no pulse when mask bit c-1 is 1.
- R8: With the latched 56 kb/s control at 1, bit 8 of every channel gives no pulse. The other bits of the channel are unaffected.
- R9: A bit is gapped if any enabled rule selects it.
- R10: `dont_care_o` is high in exactly the cycle where a ticked bit is gapped, and in no other cycle.
- R11: The gap controls and the mask are latched only on a ticked frame start, and the frame-start bit itself uses the new values. Changes made in the middle of a frame take effect at the next frame start. Before the first frame start after reset, no bit is gapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per 1.544 Mb/s line bit |
| frame_start | input | 1 | Marks the ticked bit as the framing bit |
| fbit_gap_en | input | 1 | Blank the framing bit |
| chan_gap_en | input | 1 | Blank the channels selected in `chan_mask` |
| chan_mask | input | 24 | Bit c-1 selects channel c |
| bit8_gap_en | input | 1 | Blank bit 8 of every channel |
| clk_en_o | output | 1 | Gapped clock enable |
| pos_o | output | 8 | Frame bit position, 0 to 192 |
| chan_o | output | 5 | Channel number, 0 for the framing bit |
| bit_o | output | 4 | Bit within the channel, 1 to 8, 0 for the framing bit |
| dont_care_o | output | 1 | The bit just ticked is gapped; its data is meaningless |

## Verification
Two things can land on the same tick: the latching of new settings, and their first use to judge the framing bit. The bench changes every control and the mask on the very tick that carries a frame start. It then checks that the framing bit and the rest of that frame follow the new values. A later change made mid-frame must leave the rest of that frame untouched. The second collision is a frame start arriving early, in the middle of a frame, together with a tick. The counter must jump straight to 0 and must not simply step forward.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
    localparam int GSC_CHANNELS_DEF = 24;
    localparam int GSC_CH_BITS_DEF  = 8;

    // number of bit slots in one frame: framing bit plus all channel bits
    function automatic int frame_slots(input int n_ch, input int ch_bits);
        return n_ch * ch_bits + 1;
    endfunction
endpackage

// File: rtl/gsc_position.sv
module gsc_position #(
    parameter int POS_W    = 8,
    parameter int LAST_POS = 192
) (
    input  logic [POS_W-1:0] pos_q,
    input  logic             restart,
    output logic [POS_W-1:0] pos_next
);
    always_comb begin
        if (restart || pos_q == POS_W'(LAST_POS)) begin
            pos_next = '0;
        end else begin
            pos_next = pos_q + 1'b1;
        end
    end
endmodule

// File: rtl/gsc_decode.sv
module gsc_decode #(
    parameter int POS_W   = 8,
    parameter int CH_W    = 5,
    parameter int BIT_W   = 4,
    parameter int CH_BITS = 8
) (
    input  logic [POS_W-1:0] pos,
    output logic             is_fbit,
    output logic [CH_W-1:0]  chan,
    output logic [BIT_W-1:0] bitn
);
    int unsigned offs;

    always_comb begin
        offs    = 0;
        is_fbit = (pos == '0);
        chan    = '0;
        bitn    = '0;
        if (!is_fbit) begin
            offs = int'(pos) - 1;
            chan = CH_W'(offs / CH_BITS + 1);
            bitn = BIT_W'(offs % CH_BITS + 1);
        end
    end
endmodule

// File: rtl/gsc_gap_rule.sv
module gsc_gap_rule #(
    parameter int N_CH    = 24,
    parameter int CH_BITS = 8,
    parameter int CH_W    = 5,
    parameter int BIT_W   = 4
) (
    input  logic             is_fbit,
    input  logic [CH_W-1:0]  chan,
    input  logic [BIT_W-1:0] bitn,
    input  logic             fbit_gap,
    input  logic             chan_gap,
    input  logic             bit8_gap,
    input  logic [N_CH-1:0]  mask,
    output logic             gap
);
    logic [N_CH-1:0] sel;

    for (genvar c = 0; c < N_CH; c++) begin : g_chan_sel
        assign sel[c] = mask[c] && (chan == CH_W'(c + 1));
    end

    logic chan_hit;
    logic last_bit;

    assign chan_hit = |sel;
    assign last_bit = (bitn == BIT_W'(CH_BITS));

    always_comb begin
        if (is_fbit) begin
            gap = fbit_gap;
        end else begin
            gap = (chan_gap && chan_hit) || (bit8_gap && last_bit);
        end
    end
endmodule

// File: rtl/gapped_sysclk_gen.sv
module gapped_sysclk_gen #(
    parameter int N_CH       = gsc_pkg::GSC_CHANNELS_DEF,
    parameter int CH_BITS    = gsc_pkg::GSC_CH_BITS_DEF,
    localparam int FRAME_BITS = gsc_pkg::frame_slots(N_CH, CH_BITS),
    localparam int LAST_POS   = FRAME_BITS - 1,
    localparam int POS_W      = $clog2(FRAME_BITS),
    localparam int CH_W       = $clog2(N_CH + 1),
    localparam int BIT_W      = $clog2(CH_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             frame_start,
    input  logic             fbit_gap_en,
    input  logic             chan_gap_en,
    input  logic [N_CH-1:0]  chan_mask,
    input  logic             bit8_gap_en,
    output logic             clk_en_o,
    output logic [POS_W-1:0] pos_o,
    output logic [CH_W-1:0]  chan_o,
    output logic [BIT_W-1:0] bit_o,
    output logic             dont_care_o
);
    typedef struct packed {
        logic            fg;
        logic            cg;
        logic            b8;
        logic [N_CH-1:0] mask;
    } cfg_t;

    typedef struct packed {
        cfg_t             cfg;
        logic [POS_W-1:0] pos;
        logic             en;
        logic             dc;
    } state_t;

    state_t st_d, st_q;

    logic             restart;
    logic [POS_W-1:0] pos_next;
    cfg_t             cfg_live;
    cfg_t             cfg_eff;
    logic             nx_fbit;
    logic [CH_W-1:0]  nx_chan;
    logic [BIT_W-1:0] nx_bit;
    logic             gap;
    logic             out_fbit;

    assign restart  = bit_tick && frame_start;
    assign cfg_live = '{fg: fbit_gap_en, cg: chan_gap_en, b8: bit8_gap_en, mask: chan_mask};
    assign cfg_eff  = restart ? cfg_live : st_q.cfg;

    gsc_position #(
        .POS_W    (POS_W),
        .LAST_POS (LAST_POS)
    ) i_position (
        .pos_q    (st_q.pos),
        .restart  (restart),
        .pos_next (pos_next)
    );

    gsc_decode #(
        .POS_W   (POS_W),
        .CH_W    (CH_W),
        .BIT_W   (BIT_W),
        .CH_BITS (CH_BITS)
    ) i_decode_next (
        .pos     (pos_next),
        .is_fbit (nx_fbit),
        .chan    (nx_chan),
        .bitn    (nx_bit)
    );

    gsc_gap_rule #(
        .N_CH    (N_CH),
        .CH_BITS (CH_BITS),
        .CH_W    (CH_W),
        .BIT_W   (BIT_W)
    ) i_gap_rule (
        .is_fbit  (nx_fbit),
        .chan     (nx_chan),
        .bitn     (nx_bit),
        .fbit_gap (cfg_eff.fg),
        .chan_gap (cfg_eff.cg),
        .bit8_gap (cfg_eff.b8),
        .mask     (cfg_eff.mask),
        .gap      (gap)
    );

    always_comb begin
        st_d    = st_q;
        st_d.en = 1'b0;
        st_d.dc = 1'b0;
        if (bit_tick) begin
            if (frame_start) begin
                st_d.cfg = cfg_live;
            end
            st_d.pos = pos_next;
            st_d.en  = !gap;
            st_d.dc  = gap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pos <= POS_W'(LAST_POS);
        end else begin
            st_q <= st_d;
        end
    end

    gsc_decode #(
        .POS_W   (POS_W),
        .CH_W    (CH_W),
        .BIT_W   (BIT_W),
        .CH_BITS (CH_BITS)
    ) i_decode_out (
        .pos     (st_q.pos),
        .is_fbit (out_fbit),
        .chan    (chan_o),
        .bitn    (bit_o)
    );

    assign clk_en_o    = st_q.en;
    assign dont_care_o = st_q.dc;
    assign pos_o       = st_q.pos;
endmodule

// File: rtl/gsc_checker.sv
module gsc_checker #(
    parameter int N_CH    = 24,
    parameter int CH_BITS = 8,
    parameter int POS_W   = 8,
    parameter int CH_W    = 5,
    parameter int BIT_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             frame_start,
    input logic             fbit_gap_en,
    input logic             clk_en_o,
    input logic [POS_W-1:0] pos_o,
    input logic [CH_W-1:0]  chan_o,
    input logic [BIT_W-1:0] bit_o,
    input logic             dont_care_o
);
    localparam int LAST = N_CH * CH_BITS;

    p_no_tick_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> (!clk_en_o && !dont_care_o));

    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && frame_start) |=> (pos_o == '0));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !frame_start && pos_o == POS_W'(LAST)) |=> (pos_o == '0));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !frame_start && pos_o != POS_W'(LAST)) |=> (pos_o == $past(pos_o) + 1'b1));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(pos_o));

    p_fbit_decode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o == '0) |-> (chan_o == '0 && bit_o == '0));

    p_fbit_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && frame_start && fbit_gap_en) |=> (dont_care_o && !clk_en_o));

    p_gap_no_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dont_care_o |-> !clk_en_o);

    p_tick_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> (clk_en_o != dont_care_o));
endmodule

bind gapped_sysclk_gen gsc_checker #(
    .N_CH    (N_CH),
    .CH_BITS (CH_BITS),
    .POS_W   (POS_W),
    .CH_W    (CH_W),
    .BIT_W   (BIT_W)
) i_gsc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .frame_start (frame_start),
    .fbit_gap_en (fbit_gap_en),
    .clk_en_o    (clk_en_o),
    .pos_o       (pos_o),
    .chan_o      (chan_o),
    .bit_o       (bit_o),
    .dont_care_o (dont_care_o)
);

// File: tb/test_gapped_sysclk_gen.sv
module test_gapped_sysclk_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 24;
    localparam int LASTP = 192;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bit_tick = 1'b0;
    logic           frame_start = 1'b0;
    logic           fbit_gap_en = 1'b0;
    logic           chan_gap_en = 1'b0;
    logic [NCH-1:0] chan_mask = '0;
    logic           bit8_gap_en = 1'b0;
    logic           clk_en_o;
    logic [7:0]     pos_o;
    logic [4:0]     chan_o;
    logic [3:0]     bit_o;
    logic           dont_care_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model of latched settings and position
    bit           m_fg, m_cg, m_b8;
    bit [NCH-1:0] m_mask;
    int           m_pos;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gapped_sysclk_gen i_gapped_sysclk_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .frame_start (frame_start),
        .fbit_gap_en (fbit_gap_en),
        .chan_gap_en (chan_gap_en),
        .chan_mask   (chan_mask),
        .bit8_gap_en (bit8_gap_en),
        .clk_en_o    (clk_en_o),
        .pos_o       (pos_o),
        .chan_o      (chan_o),
        .bit_o       (bit_o),
        .dont_care_o (dont_care_o)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_gap(input int p);
        if (p == 0) return m_fg;
        return (m_cg && m_mask[(p - 1) / 8]) || (m_b8 && ((p - 1) % 8) == 7);
    endfunction

    function automatic string gap_tag(input int p);
        if (p == 0) return "R6";
        if (m_cg && m_mask[(p - 1) / 8]) return "R7";
        if (m_b8 && ((p - 1) % 8) == 7) return "R8";
        return "R2";
    endfunction

    task automatic set_live(input bit fg, input bit cg, input logic [NCH-1:0] mask, input bit b8);
        fbit_gap_en = fg;
        chan_gap_en = cg;
        chan_mask   = mask;
        bit8_gap_en = b8;
    endtask

    // drive one cycle, then check the registered outputs just after the edge
    task automatic step(input bit fs, input bit tk, input string tag);
        bit g;
        bit e_en;
        bit e_dc;
        int e_ch;
        int e_bt;
        @(negedge clk);
        bit_tick    = tk;
        frame_start = fs;
        @(posedge clk);
        #1;
        e_en = 0;
        e_dc = 0;
        if (tk) begin
            if (fs) begin
                m_fg = fbit_gap_en; m_cg = chan_gap_en; m_b8 = bit8_gap_en; m_mask = chan_mask;
                m_pos = 0;
            end else begin
                m_pos = (m_pos == LASTP) ? 0 : m_pos + 1;
            end
            g    = exp_gap(m_pos);
            e_en = !g;
            e_dc = g;
        end
        e_ch = (m_pos == 0) ? 0 : (m_pos - 1) / 8 + 1;
        e_bt = (m_pos == 0) ? 0 : (m_pos - 1) % 8 + 1;
        check(clk_en_o == e_en, tk ? {tag, " ", gap_tag(m_pos)} : "R2", "clk_en_o", int'(clk_en_o), int'(e_en));
        check(dont_care_o == e_dc, "R10", "dont_care_o", int'(dont_care_o), int'(e_dc));
        check(int'(pos_o) == m_pos, (tk && fs) ? "R3" : "R4", "pos_o", int'(pos_o), m_pos);
        check(int'(chan_o) == e_ch, "R5", "chan_o", int'(chan_o), e_ch);
        check(int'(bit_o) == e_bt, "R5", "bit_o", int'(bit_o), e_bt);
        bit_tick    = 1'b0;
        frame_start = 1'b0;
    endtask

    task automatic run_frame(input string tag);
        step(1'b1, 1'b1, tag);
        for (int i = 1; i <= LASTP; i++) step(1'b0, 1'b1, tag);
    endtask

    // R1: reset values
    task automatic t_reset();
        check(int'(pos_o) == LASTP, "R1", "pos_o after reset", int'(pos_o), LASTP);
        check(clk_en_o == 1'b0, "R1", "clk_en_o after reset", int'(clk_en_o), 0);
        check(dont_care_o == 1'b0, "R1", "dont_care_o after reset", int'(dont_care_o), 0);
    endtask

    // R11: controls set before any frame start gap nothing; free wrap 192 -> 0 (R4)
    task automatic t_before_first_frame();
        set_live(1'b1, 1'b1, '1, 1'b1);
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, "R11");
        set_live(1'b0, 1'b0, '0, 1'b0);
    endtask

    // R2 R3 R4 R5: ungapped frame, idle cycles, wrap, ignored lone frame_start
    task automatic t_plain();
        run_frame("R2");
        step(1'b0, 1'b1, "R4");
        step(1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, "R3");
        step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, "R4");
    endtask

    // R3: frame start arriving mid-frame restarts the count
    task automatic t_early_restart();
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, "R4");
        step(1'b1, 1'b1, "R3");
        step(1'b0, 1'b1, "R3");
    endtask

    task automatic t_fbit();
        set_live(1'b1, 1'b0, '0, 1'b0);
        run_frame("R6");
    endtask

    task automatic t_chan();
        set_live(1'b0, 1'b1, 24'h80_0421, 1'b0);
        run_frame("R7");
    endtask

    task automatic t_bit8();
        set_live(1'b0, 1'b0, '1, 1'b1);
        run_frame("R8");
    endtask

    // R9: overlapping rules combine
    task automatic t_combined();
        set_live(1'b1, 1'b1, 24'h00_F00C, 1'b1);
        run_frame("R9");
    endtask

    // R11: mid-frame change held off; new values used from the frame-start bit on
    task automatic t_capture();
        set_live(1'b0, 1'b1, 24'h00_0001, 1'b0);
        step(1'b1, 1'b1, "R11");
        set_live(1'b1, 1'b1, 24'hFF_FFFE, 1'b1);
        for (int i = 1; i <= LASTP; i++) step(1'b0, 1'b1, "R11");
        run_frame("R11");
        set_live(1'b0, 1'b0, '0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        m_fg = 0; m_cg = 0; m_b8 = 0; m_mask = '0; m_pos = LASTP;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_before_first_frame();
        t_plain();
        t_early_restart();
        t_fbit();
        t_chan();
        t_bit8();
        t_combined();
        t_capture();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule